// File: doc/BRIEF.md
# Upper-memory bank switch decoder

This block decides where the top 12 KB of a 16-bit address space is served from. The processor reaches it through a window of sixteen control addresses. A read strobe on any one of those addresses chooses one of two 4 KB RAM banks for the 4 KB region at 0xD000. The same access chooses whether reads of the 0xD000 and 0xE000 regions come from ROM or from RAM, and whether writes to those regions reach RAM. The read mapping and the write mapping are held apart, so software can copy ROM into RAM with the same address range selected for both directions.

The outputs are chip selects, decoded from the address alone: one ROM read select; four bank read selects and four bank write selects for the 4 KB region, covering main and alternate copies of bank 1 and bank 2; and two read selects and two write selects for the 8 KB region at 0xE000, main and alternate. The alternate zero-page flag picks the alternate copy. The memories qualify the selects with their own strobes.

A status read returns whether RAM reads are active. Control accesses return zero on the data port. Inside, the mapping is a four-state machine plus a bank flag:
- `MODE_RAM_PROTECT`: read RAM, writes blocked.
- `MODE_ROM_WRITE`: read ROM, writes to RAM.
- `MODE_ROM_PROTECT`: read ROM, writes blocked. This is the reset state.
- `MODE_RAM_WRITE`: read RAM, writes to RAM.

Every control access takes the transition named by its two low address bits: 00 goes to RAM_PROTECT, 01 to ROM_WRITE, 10 to ROM_PROTECT and 11 to RAM_WRITE. It also reloads the bank flag. Any other cycle takes the hold transition.

Top module: `lc_bank_decoder`

## Requirements
- R1: The mapping changes only on a cycle with `cpu_rd` high and `cpu_addr & 0xFFF0 == 0xC080`. It takes effect from the next clock. An address outside that window, or a cycle with `cpu_rd` low, leaves the mapping unchanged.
- R2: On a control access, address bit 3 = 1 selects bank 1 and bit 3 = 0 selects bank 2.
- R3: On a control access, RAM writes become enabled exactly when address bit 0 is 1.
- R4: On a control access, reads come from ROM when address bit 1 XOR bit 0 is 1, and from RAM otherwise.
- R5: When reads come from ROM, `rom_rd_sel` is high for addresses 0xD000–0xFFFF, and every RAM read select is low.
- R6: When reads come from RAM, the 0xD000–0xDFFF region raises exactly one bit of `d_rd_sel`. Bit 0 is main bank 1, bit 1 is main bank 2, bit 2 is alternate bank 1 and bit 3 is alternate bank 2. The alternate bits are used when `alt_zp` = 1.
- R7: When reads come from RAM, the 0xE000–0xFFFF region raises `e_rd_sel` bit 0 (main) when `alt_zp` = 0, and bit 1 (alternate) when `alt_zp` = 1.
- R8: `d_wr_sel` and `e_wr_sel` follow the same bit layout and copy choice as the read selects. They are active only while writes are enabled, whatever the read source.
- R9: A read strobe on a control address drives `data_oe` = 1 with `data_out` = 0x00. A read strobe on 0xC012 drives `data_oe` = 1 with bit 7 = 1 exactly when RAM reads are active, and the other bits 0.
- R10: After reset, bank 2 is selected, reads come from ROM and writes are disabled.
- R11: For any address, at most one read select and at most one write select is active. Addresses below 0xD000 activate none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read strobe |
| alt_zp | input | 1 | Alternate zero-page flag; picks the alternate RAM copy |
| rom_rd_sel | output | 1 | ROM read select for 0xD000–0xFFFF |
| d_rd_sel | output | 4 | 0xD000 region read selects {alt b2, alt b1, main b2, main b1} |
| e_rd_sel | output | 2 | 0xE000 region read selects {alt, main} |
| d_wr_sel | output | 4 | 0xD000 region write selects, same layout |
| e_wr_sel | output | 2 | 0xE000 region write selects, same layout |
| data_out | output | 8 | Read data for control and status addresses |
| data_oe | output | 1 | `data_out` is valid |
| stat_bank1 | output | 1 | Bank 1 selected |
| stat_read_ram | output | 1 | Reads come from RAM |
| stat_write_ram | output | 1 | Writes to RAM enabled |

## Verification
The bench drives every one of the sixteen control codes and, after each, checks both regions with both values of `alt_zp`. This catches an inverted XOR, for example a design that decodes read-from-ROM from bit 1 alone: it would show ROM where RAM is expected for code 11. The same sweep catches a swapped bank sense.

Code 01 is the sharpest case. A decoder that tied writes to the read source would leave the write selects dead while the ROM select is high.

The bench also checks that near misses do not change the mapping: 0xC090, 0xC07F, and a control address presented without a strobe. A decoder that dropped the strobe, or matched too few address bits, would change the mapping on these accesses. Reads of the status address before and after a switch show whether bit 7 follows the read source.

// File: rtl/lc_pkg.sv
package lc_pkg;

    // Encoding equals the two low bits of the control address that enters the state.
    typedef enum logic [1:0] {
        MODE_RAM_PROTECT = 2'b00,
        MODE_ROM_WRITE   = 2'b01,
        MODE_ROM_PROTECT = 2'b10,
        MODE_RAM_WRITE   = 2'b11
    } lc_mode_e;

    typedef struct packed {
        logic bank1;
        logic rd_ram;
        logic wr_ram;
    } lc_map_t;

endpackage

// File: rtl/lc_ctrl_fsm.sv
module lc_ctrl_fsm
    import lc_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'hC080,
    parameter logic [ADDR_W-1:0] CTRL_MASK = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output lc_map_t           map_o,
    output logic              ctrl_hit_o
);

    lc_mode_e state_q, state_d;
    logic     bank1_q, bank1_d;
    logic     take;

    assign ctrl_hit_o = ((addr & CTRL_MASK) == CTRL_BASE);
    assign take       = rd && ctrl_hit_o;

    // Next-state: every control access takes the transition named by addr[1:0].
    always_comb begin
        state_d = state_q;
        bank1_d = bank1_q;
        if (take) begin
            bank1_d = addr[3];
            unique case (addr[1:0])
                2'b00:   state_d = MODE_RAM_PROTECT;
                2'b01:   state_d = MODE_ROM_WRITE;
                2'b10:   state_d = MODE_ROM_PROTECT;
                default: state_d = MODE_RAM_WRITE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_ROM_PROTECT;
            bank1_q <= 1'b0;
        end else begin
            state_q <= state_d;
            bank1_q <= bank1_d;
        end
    end

    // Output decode of the state.
    always_comb begin
        map_o.bank1 = bank1_q;
        unique case (state_q)
            MODE_RAM_PROTECT: begin map_o.rd_ram = 1'b1; map_o.wr_ram = 1'b0; end
            MODE_ROM_WRITE:   begin map_o.rd_ram = 1'b0; map_o.wr_ram = 1'b1; end
            MODE_ROM_PROTECT: begin map_o.rd_ram = 1'b0; map_o.wr_ram = 1'b0; end
            default:          begin map_o.rd_ram = 1'b1; map_o.wr_ram = 1'b1; end
        endcase
    end

    AST_HOLD_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && ((addr & CTRL_MASK) == CTRL_BASE)) |=> $stable(map_o)) else $error("hold"); // R1
    AST_BANK_FROM_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ((addr & CTRL_MASK) == CTRL_BASE)) |=> (map_o.bank1 == $past(addr[3]))) else $error("bank"); // R2
    AST_WRITE_FROM_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ((addr & CTRL_MASK) == CTRL_BASE)) |=> (map_o.wr_ram == $past(addr[0]))) else $error("wr"); // R3
    AST_READ_FROM_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ((addr & CTRL_MASK) == CTRL_BASE)) |=> (map_o.rd_ram == !($past(addr[1]) ^ $past(addr[0])))) else $error("rd"); // R4

endmodule

// File: rtl/lc_region_decode.sv
module lc_region_decode
    import lc_pkg::*;
#(
    parameter int         ADDR_W = 16,
    parameter logic [3:0] LO_TAG = 4'hD,
    parameter logic [2:0] HI_TAG = 3'b111,
    parameter int         NBANK  = 2,
    parameter int         NCOPY  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    alt_zp,
    input  lc_map_t                 map_i,
    output logic                    rom_rd,
    output logic [NBANK*NCOPY-1:0]  d_rd,
    output logic [NCOPY-1:0]        e_rd,
    output logic [NBANK*NCOPY-1:0]  d_wr,
    output logic [NCOPY-1:0]        e_wr
);

    logic in_d, in_e;
    assign in_d   = (addr[ADDR_W-1 -: 4] == LO_TAG);
    assign in_e   = (addr[ADDR_W-1 -: 3] == HI_TAG);
    assign rom_rd = (in_d || in_e) && !map_i.rd_ram;

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        logic copy_hit;
        assign copy_hit = (alt_zp == (c == 1));
        assign e_rd[c]  = in_e && map_i.rd_ram && copy_hit;
        assign e_wr[c]  = in_e && map_i.wr_ram && copy_hit;
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic bank_hit;
            assign bank_hit          = (map_i.bank1 == (b == 0));
            assign d_rd[c*NBANK + b] = in_d && map_i.rd_ram && copy_hit && bank_hit;
            assign d_wr[c*NBANK + b] = in_d && map_i.wr_ram && copy_hit && bank_hit;
        end
    end

    AST_ONE_READ_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rom_rd, d_rd, e_rd}) <= 1) else $error("rd sel"); // R11
    AST_ONE_WRITE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({d_wr, e_wr})) else $error("wr sel"); // R11
    AST_ROM_EXCLUDES_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> ({d_rd, e_rd} == '0)) else $error("rom"); // R5
    AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !map_i.wr_ram |-> ({d_wr, e_wr} == '0)) else $error("wr en"); // R8

endmodule

// File: rtl/lc_status_read.sv
module lc_status_read
    import lc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hC012
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              ctrl_hit,
    input  lc_map_t           map_i,
    output logic [DATA_W-1:0] data_o,
    output logic              oe_o
);

    logic stat_hit;
    assign stat_hit = (addr == STAT_ADDR);
    assign oe_o     = rd && (ctrl_hit || stat_hit);

    always_comb begin
        data_o = '0;
        if (rd && stat_hit) data_o[DATA_W-1] = map_i.rd_ram;
    end

    AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ctrl_hit) |-> (oe_o && data_o == '0)) else $error("ctrl data"); // R9

endmodule

// File: rtl/lc_bank_decoder.sv
module lc_bank_decoder
    import lc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              alt_zp,
    output logic              rom_rd_sel,
    output logic [3:0]        d_rd_sel,
    output logic [1:0]        e_rd_sel,
    output logic [3:0]        d_wr_sel,
    output logic [1:0]        e_wr_sel,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              stat_bank1,
    output logic              stat_read_ram,
    output logic              stat_write_ram
);

    localparam int NBANK = 2;
    localparam int NCOPY = 2;

    lc_map_t map;
    logic    ctrl_hit;

    lc_ctrl_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd(cpu_rd),
        .map_o(map), .ctrl_hit_o(ctrl_hit)
    );

    lc_region_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK), .NCOPY(NCOPY)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .alt_zp(alt_zp), .map_i(map),
        .rom_rd(rom_rd_sel), .d_rd(d_rd_sel), .e_rd(e_rd_sel),
        .d_wr(d_wr_sel), .e_wr(e_wr_sel)
    );

    lc_status_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd(cpu_rd),
        .ctrl_hit(ctrl_hit), .map_i(map), .data_o(data_out), .oe_o(data_oe)
    );

    assign stat_bank1     = map.bank1;
    assign stat_read_ram  = map.rd_ram;
    assign stat_write_ram = map.wr_ram;

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(!rst_n) |-> (!stat_bank1 && !stat_read_ram && !stat_write_ram)) else $error("reset"); // R10

endmodule

// File: tb/lc_bank_decoder_test.sv
module lc_bank_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0;
    logic        alt_zp = 1'b0;
    logic        rom_rd_sel;
    logic [3:0]  d_rd_sel, d_wr_sel;
    logic [1:0]  e_rd_sel, e_wr_sel;
    logic [7:0]  data_out;
    logic        data_oe, stat_bank1, stat_read_ram, stat_write_ram;

    int checks = 0;
    int errors = 0;
    logic m_bank1, m_rdram, m_wrram;

    always #5 clk = ~clk;

    lc_bank_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .alt_zp(alt_zp),
        .rom_rd_sel(rom_rd_sel), .d_rd_sel(d_rd_sel), .e_rd_sel(e_rd_sel),
        .d_wr_sel(d_wr_sel), .e_wr_sel(e_wr_sel), .data_out(data_out), .data_oe(data_oe),
        .stat_bank1(stat_bank1), .stat_read_ram(stat_read_ram), .stat_write_ram(stat_write_ram)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One read strobe cycle on addr; the model follows R1-style rules separately.
    task automatic strobe(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h0000;
    endtask

    task automatic ctrl(input logic [3:0] code);
        strobe(16'hC080 | {12'h0, code});
        m_bank1 = code[3];
        m_wrram = code[0];
        m_rdram = !(code[1] ^ code[0]);
    endtask

    // Compare every select for one address and alt flag against the model.
    task automatic probe(input string req, input logic [15:0] a, input logic alt);
        logic ind, ine;
        logic [3:0] ed_rd, ed_wr;
        logic [1:0] ee_rd, ee_wr;
        int idx;
        ind = (a[15:12] == 4'hD);
        ine = (a[15:13] == 3'b111);
        idx = (alt ? 2 : 0) + (m_bank1 ? 0 : 1);
        ed_rd = 4'h0; ed_wr = 4'h0; ee_rd = 2'h0; ee_wr = 2'h0;
        if (ind && m_rdram) ed_rd[idx] = 1'b1;
        if (ind && m_wrram) ed_wr[idx] = 1'b1;
        if (ine && m_rdram) ee_rd[alt ? 1 : 0] = 1'b1;
        if (ine && m_wrram) ee_wr[alt ? 1 : 0] = 1'b1;
        @(negedge clk);
        cpu_addr = a; alt_zp = alt; cpu_rd = 1'b0;
        #2;
        check({req, " rom_rd_sel"}, {31'h0, rom_rd_sel}, {31'h0, (ind || ine) && !m_rdram});
        check({req, " d_rd_sel"}, {28'h0, d_rd_sel}, {28'h0, ed_rd});
        check({req, " e_rd_sel"}, {30'h0, e_rd_sel}, {30'h0, ee_rd});
        check({req, " d_wr_sel"}, {28'h0, d_wr_sel}, {28'h0, ed_wr});
        check({req, " e_wr_sel"}, {30'h0, e_wr_sel}, {30'h0, ee_wr});
        check("R11 read onehot", {31'h0, ($countones({rom_rd_sel, d_rd_sel, e_rd_sel}) <= 1)}, 32'h1);
        check("R11 write onehot", {31'h0, ($countones({d_wr_sel, e_wr_sel}) <= 1)}, 32'h1);
    endtask

    task automatic status(input string req);
        @(negedge clk);
        cpu_addr = 16'hC012; cpu_rd = 1'b1;
        #2;
        check({req, " status oe"}, {31'h0, data_oe}, 32'h1);
        check({req, " status data"}, {24'h0, data_out}, {24'h0, m_rdram, 7'h0});
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h0000;
    endtask

    task automatic t_reset;
        m_bank1 = 1'b0; m_rdram = 1'b0; m_wrram = 1'b0;
        check("R10 bank1", {31'h0, stat_bank1}, 32'h0);
        check("R10 read ram", {31'h0, stat_read_ram}, 32'h0);
        check("R10 write ram", {31'h0, stat_write_ram}, 32'h0);
        probe("R10 R5 D", 16'hD123, 1'b0);
        probe("R10 R5 E", 16'hF000, 1'b1);
    endtask

    task automatic t_all_codes;
        for (int c = 0; c < 16; c++) begin
            ctrl(c[3:0]);
            check("R2 bank", {31'h0, stat_bank1}, {31'h0, m_bank1});
            check("R3 write", {31'h0, stat_write_ram}, {31'h0, m_wrram});
            check("R4 read", {31'h0, stat_read_ram}, {31'h0, m_rdram});
            for (int al = 0; al < 2; al++) begin
                probe("R6 R8 D region", 16'hD800, al[0]);
                probe("R7 R8 E region", 16'hE400, al[0]);
                probe("R11 low addr", 16'h2000, al[0]);
            end
        end
    endtask

    task automatic t_ctrl_data;
        @(negedge clk);
        cpu_addr = 16'hC08B; cpu_rd = 1'b1;
        #2;
        check("R9 ctrl oe", {31'h0, data_oe}, 32'h1);
        check("R9 ctrl data", {24'h0, data_out}, 32'h0);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h0000;
        m_bank1 = 1'b1; m_wrram = 1'b1; m_rdram = 1'b1;
        status("R9 ram");
        ctrl(4'h2);
        status("R9 rom");
    endtask

    task automatic t_write_independent;
        ctrl(4'h1);
        probe("R8 write while rom read D", 16'hDFFF, 1'b0);
        probe("R8 write while rom read E", 16'hFFFF, 1'b1);
    endtask

    task automatic t_no_effect;
        ctrl(4'h2);
        @(negedge clk);
        cpu_addr = 16'hC08B; cpu_rd = 1'b0;
        @(negedge clk);
        strobe(16'hC090);
        strobe(16'hC07F);
        probe("R1 no change D", 16'hD000, 1'b0);
        check("R1 read ram", {31'h0, stat_read_ram}, 32'h0);
        check("R1 write ram", {31'h0, stat_write_ram}, 32'h0);
        check("R1 bank", {31'h0, stat_bank1}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        t_reset();
        t_all_codes();
        t_ctrl_data();
        t_write_independent();
        t_no_effect();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule